// File: doc/BRIEF.md
# Gaussian Transmit Data Shaping Filter

This block turns a serial one-bit transmit stream into a stream of signed, multi-bit modulation samples whose frequency spectrum has been narrowed by a Gaussian-shaped FIR. It runs on a filter clock that ticks six times per symbol. It samples the data line once per symbol and maps each bit to an antipodal level. It pushes that level through a 12-tap delay line with fixed symmetric coefficients, and it produces one shaped sample on every filter clock while it is enabled.

The summed filter output is scaled by a 3-bit trim code from 60% to 130% in 10% steps, rounded to the nearest integer and optionally negated so that a downstream modulator can use either deviation sense. The result saturates to the output word. When the filter is switched off, for example while receiving, the output is forced to zero and the delay line is flushed. The next transmit burst therefore starts from a clean state.

Top module: `txg_gauss_filter`

## Requirements
- R1: While reset is high and on the first edge after it, `sample_out` is 0 and `sample_valid` is 0.
- R2: A clock edge with `en` low drives `sample_out` to 0 and `sample_valid` to 0 and clears every tap of the delay line to level 0.
- R3: `sample_valid` goes high on every clock edge at which `en` is high.
- R4: `tx_bit` is captured on the first enabled edge after `en` rises and on every 6th enabled edge after that. Changes of `tx_bit` between those edges have no effect. The captured level is shifted into the delay line on each of the 6 edges of its symbol.
- R5: Bit 1 maps to level +1 and bit 0 to level -1. The taps hold the coefficients 2, 6, 12, 22, 36, 50, 50, 36, 22, 12, 6, 2, and their sum of 256 is unity gain. The filter sum taken at an edge uses the delay line contents from before that edge, with the newest entry on the first coefficient.
- R6: Gain code g (0..7) scales the filter sum by (6+g)/10. The result is rounded to the nearest integer, with halves rounded away from zero. At code 4 a constant stream settles at the full-scale value of ±256 before saturation.
- R7: With `polarity` = 1 the scaled value is output unchanged. With `polarity` = 0 it is negated before saturation.
- R8: The output saturates to the range -2^(OUT_W-1) to 2^(OUT_W-1)-1, which is -256 to 255 for the default 9-bit output.
- R9: A change of `gain_code` or `polarity` shows at `sample_out` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock, six ticks per symbol |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Filter enable; low forces zero output |
| tx_bit | input | 1 | Serial transmit data |
| polarity | input | 1 | 1: output as computed, 0: output negated |
| gain_code | input | 3 | Output trim, (6+code)×10 percent |
| sample_out | output | OUT_W | Signed shaped modulation sample |
| sample_valid | output | 1 | High for each sample produced while enabled |

## Verification
Every tap feeds the output on every cycle, so a corrupted delay line entry or a wrong coefficient shows as a wrong sample on the very next edge. It stays visible for up to 12 edges as the entry moves down the line. This is why the step response is checked at each edge rather than only in steady state. A symbol-phase counter that drifts shows as a level change landing one or more edges away from the 6-edge boundary. A scaling or polarity fault shows at once in the settled value of a constant stream.

// File: rtl/txg_pkg.sv
package txg_pkg;

    localparam int TAPS      = 12;
    localparam int OSR       = 6;
    localparam int COEF_FRAC = 8;
    localparam int GAIN_W    = 3;
    localparam int GAIN_BASE = 6;
    localparam int PH_W      = $clog2(OSR);
    localparam int ACC_W     = COEF_FRAC + 2;
    localparam int UNITY     = 1 << COEF_FRAC;

    typedef logic signed [1:0]       sym_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic              pol;
    } scale_cfg_t;

    // symmetric coefficient set; half table mirrored around the centre
    function automatic int coef(int idx);
        int h;
        h = (idx < TAPS / 2) ? idx : TAPS - 1 - idx;
        case (h)
            0:       return 2;
            1:       return 6;
            2:       return 12;
            3:       return 22;
            4:       return 36;
            default: return 50;
        endcase
    endfunction

    // multiply by tenths, round half away from zero
    function automatic int scale_round(int acc, int tenths);
        int p;
        int q;
        p = acc * tenths;
        q = ((p < 0 ? -p : p) + 5) / 10;
        return (p < 0) ? -q : q;
    endfunction

    function automatic int clip(int v, int w);
        int hi;
        int lo;
        hi = (1 << (w - 1)) - 1;
        lo = -(1 << (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/txg_symbol_sampler.sv
module txg_symbol_sampler
    import txg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tx_bit,
    output sym_t sym
);
    logic [PH_W-1:0] phase;
    logic            held;
    logic            cur_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            held  <= 1'b0;
        end else if (!en) begin
            phase <= '0;
        end else begin
            phase <= (phase == PH_W'(OSR - 1)) ? '0 : phase + 1'b1;
            if (phase == '0) held <= tx_bit;
        end
    end

    always_comb begin
        cur_bit = (phase == '0) ? tx_bit : held;
        sym     = cur_bit ? sym_t'(1) : sym_t'(-1);
    end

    p_phase_range_r4: assert property (@(posedge clk) disable iff (rst)
        int'(phase) < OSR);

    p_hold_mid_symbol_r4: assert property (@(posedge clk) disable iff (rst)
        (en && phase != '0) |=> $stable(held));

endmodule

// File: rtl/txg_fir_core.sv
module txg_fir_core
    import txg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  sym_t sym_in,
    output acc_t acc
);
    sym_t line [TAPS];

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst || !en) line[i] <= '0;
            else if (i == 0) line[i] <= sym_in;
            else line[i] <= line[(i == 0) ? 0 : i - 1];
        end
    end

    always_comb begin
        int s;
        s = 0;
        for (int i = 0; i < TAPS; i++) s += coef(i) * int'(line[i]);
        acc = acc_t'(s);
    end

    p_sum_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        (int'(acc) <= UNITY) && (int'(acc) >= -UNITY));

endmodule

// File: rtl/txg_scaler.sv
module txg_scaler
    import txg_pkg::*;
#(
    parameter int OUT_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  acc_t                    acc,
    input  scale_cfg_t              cfg,
    output logic signed [OUT_W-1:0] out,
    output logic                    valid
);
    int scaled;
    int signed_v;
    int limited;

    always_comb begin
        scaled   = scale_round(int'(acc), GAIN_BASE + int'(cfg.gain));
        signed_v = cfg.pol ? scaled : -scaled;
        limited  = clip(signed_v, OUT_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out   <= '0;
            valid <= 1'b0;
        end else begin
            valid <= en;
            out   <= en ? OUT_W'(limited) : '0;
        end
    end

    p_zero_sum_zero_out_r6: assert property (@(posedge clk) disable iff (rst)
        (en && acc == '0) |=> (out == '0));

endmodule

// File: rtl/txg_gauss_filter.sv
module txg_gauss_filter
    import txg_pkg::*;
#(
    parameter int OUT_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    tx_bit,
    input  logic                    polarity,
    input  logic [GAIN_W-1:0]       gain_code,
    output logic signed [OUT_W-1:0] sample_out,
    output logic                    sample_valid
);
    sym_t       sym;
    acc_t       acc;
    scale_cfg_t cfg;

    assign cfg = '{gain: gain_code, pol: polarity};

    txg_symbol_sampler u_sampler (
        .clk(clk), .rst(rst), .en(en), .tx_bit(tx_bit), .sym(sym)
    );

    txg_fir_core u_fir (
        .clk(clk), .rst(rst), .en(en), .sym_in(sym), .acc(acc)
    );

    txg_scaler #(.OUT_W(OUT_W)) u_scale (
        .clk(clk), .rst(rst), .en(en), .acc(acc), .cfg(cfg),
        .out(sample_out), .valid(sample_valid)
    );

    p_off_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (sample_out == '0 && !sample_valid));

    p_valid_follows_en_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (sample_valid == $past(en)));

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (sample_out == '0 && !sample_valid));

endmodule

// File: tb/tb_txg_gauss_filter.sv
module tb_txg_gauss_filter;
    localparam int PERIOD = 10;
    localparam int OUT_W  = 9;
    localparam int NV     = 13;
    // {bit, gain code, polarity, expected settled output}
    localparam int VEC [NV][4] = '{
        '{1, 0, 1,  154}, '{0, 0, 1, -154}, '{1, 1, 1,  179},
        '{0, 2, 1, -205}, '{1, 3, 0, -230}, '{0, 3, 0,  230},
        '{1, 4, 1,  255}, '{0, 4, 1, -256}, '{0, 4, 0,  255},
        '{1, 4, 0, -256}, '{1, 7, 1,  255}, '{0, 7, 1, -256},
        '{1, 5, 0, -256}
    };
    localparam int CO [12] = '{2, 6, 12, 22, 36, 50, 50, 36, 22, 12, 6, 2};

    logic clk = 0, rst = 1, en = 0, tx_bit = 0, polarity = 1;
    logic [2:0] gain_code = 3'd4;
    logic signed [OUT_W-1:0] sample_out;
    logic sample_valid;
    int tests = 0, fails = 0;

    txg_gauss_filter #(.OUT_W(OUT_W)) dut (
        .clk(clk), .rst(rst), .en(en), .tx_bit(tx_bit), .polarity(polarity),
        .gain_code(gain_code), .sample_out(sample_out), .sample_valid(sample_valid)
    );

    always #(PERIOD / 2) clk = ~clk;

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int prefix(int n);
        int s = 0;
        for (int i = 0; i < n && i < 12; i++) s += CO[i];
        return (s > 255) ? 255 : s;
    endfunction

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(3);
        check("R1 out in reset", int'(sample_out), 0);
        check("R1 valid in reset", int'(sample_valid), 0);
        rst = 0;
        tick();
        check("R1 out after reset", int'(sample_out), 0);

        // step response from a flushed line, gain 100 percent (R5, R3)
        en = 1; tx_bit = 1;
        for (int m = 1; m <= 14; m++) begin
            tick();
            check("R5 step response", int'(sample_out), prefix(m - 1));
            check("R3 valid while enabled", int'(sample_valid), 1);
        end

        // disable flushes and zeroes (R2)
        en = 0;
        tick();
        check("R2 out off", int'(sample_out), 0);
        check("R2 valid off", int'(sample_valid), 0);

        // mid-symbol change ignored (R4)
        en = 1; tx_bit = 1;
        tick();
        check("R2 line cleared", int'(sample_out), 0);
        tick();
        tx_bit = 0;
        for (int m = 3; m <= 7; m++) begin
            tick();
            check("R4 mid-symbol bit ignored", int'(sample_out), prefix(m - 1));
        end
        tick();
        check("R4 new symbol at 6th edge", int'(sample_out), 174);

        // settled values across gain, polarity, data (R6, R7, R8)
        for (int v = 0; v < NV; v++) begin
            tx_bit = VEC[v][0][0];
            gain_code = 3'(VEC[v][1]);
            polarity = VEC[v][2][0];
            tick(20);
            check("R6/R7/R8 settled output", int'(sample_out), VEC[v][3]);
        end

        // config change seen on next edge (R9)
        tx_bit = 1; gain_code = 3'd0; polarity = 1;
        tick(20);
        polarity = 0;
        tick();
        check("R9 polarity next edge", int'(sample_out), -154);
        gain_code = 3'd2;
        tick();
        check("R9 gain next edge", int'(sample_out), -205);

        // reset mid-run (R1)
        rst = 1;
        tick();
        check("R1 reset mid-run", int'(sample_out), 0);
        rst = 0; en = 0;
        tick();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule